// File: doc/BRIEF.md
# Compare-Match Timer

A 32-bit up-counter with a small register bank on a single-cycle bus. Each register access takes one cycle. There are two tick-enable inputs, one from the bus clock and one from a peripheral clock. The control register picks one of them. The chosen ticks pass through a programmable divider, and each divider output advances the counter by one. When the counter steps onto the value held in the compare register, a sticky status flag is set. That flag, gated by an interrupt-enable bit, drives a level interrupt.

Software reads the counter at any time, adds a delta modulo 2^32 and writes the sum to the compare register to schedule the next event. A mode bit chooses how the counter behaves at a match. In free-run mode it counts straight through the match. In restart mode it goes back to zero on the advance after reaching the compare value. A wait-mode input can freeze counting unless the control register permits counting during wait.

Top module: `cmp_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: While control bit 0 (enable) is 0 the counter does not advance.
- R3: Control bits [7:6] pick the count source: 2'b01 uses `busTick`, 2'b10 uses `perTick`, and 2'b00 or 2'b11 stops counting.
- R4: With prescaler value N (bits [11:0] at offset 0x04) the counter advances once per N+1 selected ticks; N=0 advances on every tick.
- R5: With control bit 9 set (free-run) the counter passes through a match, incrementing by one and wrapping from 0xFFFFFFFF to 0.
- R6: With control bit 9 clear (restart), the advance that follows the counter equalling the compare value loads 0.
- R7: With control bit 3 clear, a high `waitMode` freezes the counter; with bit 3 set, counting continues while `waitMode` is high.
- R8: Status bit 0 is set only when an advance moves the counter onto the compare value. Writing a compare value equal to the current count does not set it.
- R9: Writing status with bit 0 = 1 clears the flag and writing 0 leaves it unchanged. When a clear and a new match fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when interrupt-enable bit 0 (offset 0x0C) and status bit 0 are both 1.
- R11: Writing the value 0 to the control register clears the counter, the prescaler phase and the status flag.
- R12: Register offsets are: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24. The counter is read-only and a write to 0x24 leaves it unchanged. Control reads back bits 0, 3, 6, 7 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr`, combinational |
| busTick | input | 1 | Tick enable derived from the bus clock |
| perTick | input | 1 | Tick enable derived from the peripheral clock |
| waitMode | input | 1 | High while the system is in wait mode |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `busTick`, `perTick` and `waitMode` are synchronous to `clk` and are sampled only at its rising edge. They also assume that a register write lasts exactly one cycle with a stable address and data. The stimulus changes every input on the falling edge and raises each tick input for a counted number of cycles. This keeps the number of advances exact. The bench can then predict the count, the flag and `irq` from the divider and compare settings alone. Only the set-wins case drives a status write and a tick in the same cycle, and it does so on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_PRE  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_IEN  = 8'h0C;
  localparam logic [7:0] OFF_CMP  = 8'h10;
  localparam logic [7:0] OFF_CNT  = 8'h24;

  localparam int BIT_EN   = 0;
  localparam int BIT_WAIT = 3;
  localparam int SRC_LSB  = 6;
  localparam int BIT_FREE = 9;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_BUS  = 2'b01,
    SRC_PER  = 2'b10,
    SRC_NONE = 2'b11
  } srcSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearAll;
    logic advance;
    logic freeRun;
    logic statClr;
    logic cmpWr;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busTick,
  input  logic              perTick,
  input  logic              waitMode,
  output logic [DATA_W-1:0] ctrlVal,
  output logic [PRE_W-1:0]  preVal,
  output logic              irqEnBit,
  output tmrStrobe_t        strobe
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << BIT_EN) | (1 << BIT_WAIT) | (3 << SRC_LSB) | (1 << BIT_FREE));

  logic [DATA_W-1:0] ctrlQ;
  logic [PRE_W-1:0]  preQ;
  logic [PRE_W-1:0]  phaseQ;
  logic              ienQ;
  logic              ctrlWr;
  logic              clearAll;
  logic              selTick;
  logic              runOk;
  logic              tickEn;
  logic              phaseWrap;
  srcSel_e           srcSel;

  assign ctrlWr   = regWe && (regAddr == ADDR_W'(OFF_CTRL));
  assign clearAll = ctrlWr && (regWdata == '0);
  assign srcSel   = srcSel_e'(ctrlQ[SRC_LSB+1:SRC_LSB]);

  always_comb begin
    case (srcSel)
      SRC_BUS: selTick = busTick;
      SRC_PER: selTick = perTick;
      default: selTick = 1'b0;
    endcase
  end

  assign runOk     = ctrlQ[BIT_EN] && (ctrlQ[BIT_WAIT] || !waitMode);
  assign tickEn    = runOk && selTick && !clearAll;
  assign phaseWrap = (phaseQ >= preQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      preQ   <= '0;
      ienQ   <= 1'b0;
      phaseQ <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= regWdata & CTRL_MASK;
      if (regWe && (regAddr == ADDR_W'(OFF_PRE))) preQ <= regWdata[PRE_W-1:0];
      if (regWe && (regAddr == ADDR_W'(OFF_IEN))) ienQ <= regWdata[0];
      if (clearAll)    phaseQ <= '0;
      else if (tickEn) phaseQ <= phaseWrap ? '0 : phaseQ + 1'b1;
    end
  end

  assign ctrlVal         = ctrlQ;
  assign preVal          = preQ;
  assign irqEnBit        = ienQ;
  assign strobe.clearAll = clearAll;
  assign strobe.advance  = tickEn && phaseWrap;
  assign strobe.freeRun  = ctrlQ[BIT_FREE];
  assign strobe.statClr  = regWe && (regAddr == ADDR_W'(OFF_STAT)) && regWdata[0];
  assign strobe.cmpWr    = regWe && (regAddr == ADDR_W'(OFF_CMP));
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] ctrlVal,
  input  logic [PRE_W-1:0]  preVal,
  input  logic              irqEnBit,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] cmpVal,
  output logic              statusBit,
  output logic              matchPulse,
  output logic              irq
);
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] cmpQ;
  logic [DATA_W-1:0] stepVal;
  logic              statQ;
  logic              restartHit;

  assign restartHit = !strobe.freeRun && (cntQ == cmpQ);
  assign stepVal    = restartHit ? '0 : cntQ + 1'b1;
  assign matchPulse = strobe.advance && (stepVal == cmpQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      cmpQ  <= '0;
      statQ <= 1'b0;
    end else begin
      if (strobe.clearAll)     cntQ <= '0;
      else if (strobe.advance) cntQ <= stepVal;
      if (strobe.cmpWr) cmpQ <= regWdata;
      if (strobe.clearAll)     statQ <= 1'b0;
      else if (matchPulse)     statQ <= 1'b1;
      else if (strobe.statClr) statQ <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFF_CTRL): regRdata = ctrlVal;
      ADDR_W'(OFF_PRE):  regRdata = DATA_W'(preVal);
      ADDR_W'(OFF_STAT): regRdata = DATA_W'(statQ);
      ADDR_W'(OFF_IEN):  regRdata = DATA_W'(irqEnBit);
      ADDR_W'(OFF_CMP):  regRdata = cmpQ;
      ADDR_W'(OFF_CNT):  regRdata = cntQ;
      default:           regRdata = '0;
    endcase
  end

  assign cntVal    = cntQ;
  assign cmpVal    = cmpQ;
  assign statusBit = statQ;
  assign irq       = statQ && irqEnBit;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              busTick,
  input  logic              perTick,
  input  logic              waitMode,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlVal;
  logic [PRE_W-1:0]  preVal;
  logic              irqEnBit;
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] cntVal;
  logic [DATA_W-1:0] cmpVal;
  logic              statusBit;
  logic              matchPulse;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .busTick(busTick), .perTick(perTick),
    .waitMode(waitMode), .ctrlVal(ctrlVal), .preVal(preVal),
    .irqEnBit(irqEnBit), .strobe(strobe)
  );

  tmr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .ctrlVal(ctrlVal), .preVal(preVal),
    .irqEnBit(irqEnBit), .regRdata(regRdata), .cntVal(cntVal),
    .cmpVal(cmpVal), .statusBit(statusBit), .matchPulse(matchPulse),
    .irq(irq)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wdata0,
  input logic              waitMode,
  input logic              enBit,
  input logic              waitEnBit,
  input logic [1:0]        srcSel,
  input logic              freeRunBit,
  input logic              advance,
  input logic              matchPulse,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] cmpVal,
  input logic              statusBit,
  input logic              irqEnBit,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h24);

  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (cntVal == $past(cntVal)) || (cntVal == '0));

  assert_src_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b00 || srcSel == 2'b11) |=> (cntVal == $past(cntVal)) || (cntVal == '0));

  assert_free_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && freeRunBit) |=> cntVal == $past(cntVal) + 1'b1);

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !freeRunBit && cntVal == cmpVal) |=> cntVal == '0);

  assert_wait_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (waitMode && !waitEnBit) |=> (cntVal == $past(cntVal)) || (cntVal == '0));

  assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> statusBit);

  assert_zero_write_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_STAT && !wdata0 && statusBit) |=> statusBit);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (statusBit && irqEnBit));

  assert_cnt_readonly_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_CNT && !advance) |=> cntVal == $past(cntVal));
endmodule

bind cmp_timer cmp_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .wdata0(regWdata[0]), .waitMode(waitMode), .enBit(ctrlVal[0]),
  .waitEnBit(ctrlVal[3]), .srcSel(ctrlVal[7:6]), .freeRunBit(ctrlVal[9]),
  .advance(strobe.advance), .matchPulse(matchPulse), .cntVal(cntVal),
  .cmpVal(cmpVal), .statusBit(statusBit), .irqEnBit(irqEnBit), .irq(irq)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                         A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [11:0] pre;
    logic [31:0] cmp;
    logic        useBus;
    logic [7:0]  nTicks;
    logic [31:0] expCnt;
    logic        expSt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h041, 12'd0, 32'd100, 1'b1, 8'd10, 32'd10, 1'b0},  // R4 divide by 1
    '{32'h041, 12'd2, 32'd100, 1'b1, 8'd10, 32'd3,  1'b0},  // R4 divide by 3
    '{32'h041, 12'd0, 32'd5,   1'b1, 8'd5,  32'd5,  1'b1},  // R8 match
    '{32'h041, 12'd0, 32'd5,   1'b1, 8'd8,  32'd2,  1'b1},  // R6 restart
    '{32'h241, 12'd0, 32'd5,   1'b1, 8'd8,  32'd8,  1'b1},  // R5 free-run
    '{32'h081, 12'd0, 32'd100, 1'b1, 8'd10, 32'd0,  1'b0},  // R3 per selected, bus ignored
    '{32'h081, 12'd0, 32'd100, 1'b0, 8'd7,  32'd7,  1'b0},  // R3 per ticks
    '{32'h0C1, 12'd0, 32'd100, 1'b0, 8'd5,  32'd0,  1'b0},  // R3 code 11 stops
    '{32'h040, 12'd0, 32'd100, 1'b1, 8'd5,  32'd0,  1'b0},  // R2 disabled
    '{32'h001, 12'd0, 32'd100, 1'b1, 8'd5,  32'd0,  1'b0}   // R3 code 00 stops
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busTick = 1'b0;
  logic        perTick = 1'b0;
  logic        waitMode = 1'b0;
  logic        irq;
  int          nChecks = 0;
  int          nErrors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .busTick(busTick),
    .perTick(perTick), .waitMode(waitMode), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic pulse(input int n, input logic onBus);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (onBus) busTick = 1'b1; else perTick = 1'b1;
    end
    @(negedge clk);
    busTick = 1'b0; perTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
    rd(A_PRE, rv);  check("R1 pre", rv, 0);
    rd(A_STAT, rv); check("R1 stat", rv, 0);
    rd(A_IEN, rv);  check("R1 ien", rv, 0);
    rd(A_CMP, rv);  check("R1 cmp", rv, 0);
    rd(A_CNT, rv);  check("R1 cnt", rv, 0);
    check("R1 irq", 32'(irq), 0);

    for (int v = 0; v < NV; v++) begin
      wr(A_CTRL, 0);
      wr(A_PRE, 32'(VECS[v].pre));
      wr(A_CMP, VECS[v].cmp);
      wr(A_IEN, 1);
      wr(A_CTRL, VECS[v].ctrl);
      pulse(int'(VECS[v].nTicks), VECS[v].useBus);
      rd(A_CNT, rv);  check($sformatf("R2-R6 vec%0d count", v), rv, VECS[v].expCnt);
      rd(A_STAT, rv); check($sformatf("R8 vec%0d status", v), rv, 32'(VECS[v].expSt));
      check($sformatf("R10 vec%0d irq", v), 32'(irq), 32'(VECS[v].expSt));
    end

    // R9 / R10 write-one-to-clear and interrupt gating
    wr(A_CTRL, 0); wr(A_PRE, 0); wr(A_CMP, 3); wr(A_IEN, 0);
    wr(A_CTRL, 32'h241);
    pulse(3, 1'b1);
    rd(A_STAT, rv); check("R8 flag after 3", rv, 1);
    check("R10 irq masked", 32'(irq), 0);
    wr(A_IEN, 1);
    #1 check("R10 irq enabled", 32'(irq), 1);
    wr(A_STAT, 0);
    rd(A_STAT, rv); check("R9 write 0 keeps", rv, 1);
    wr(A_STAT, 1);
    rd(A_STAT, rv); check("R9 write 1 clears", rv, 0);
    check("R10 irq low after clear", 32'(irq), 0);

    // R8 compare written equal to current count
    wr(A_CMP, 3);
    pulse(2, 1'b1);
    rd(A_CNT, rv);  check("R8 count", rv, 5);
    rd(A_STAT, rv); check("R8 no match on equal write", rv, 0);
    wr(A_CMP, 7);
    pulse(2, 1'b1);
    rd(A_STAT, rv); check("R8 match on step into 7", rv, 1);

    // R9 set wins over simultaneous clear
    wr(A_CMP, 8);
    @(negedge clk);
    regAddr = A_STAT; regWdata = 1; regWe = 1'b1; busTick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; busTick = 1'b0;
    rd(A_CNT, rv);  check("R9 count 8", rv, 8);
    rd(A_STAT, rv); check("R9 set wins", rv, 1);

    // R11 zero write clears count, status, phase
    wr(A_CTRL, 0);
    rd(A_CNT, rv);  check("R11 count cleared", rv, 0);
    rd(A_STAT, rv); check("R11 status cleared", rv, 0);
    wr(A_PRE, 3); wr(A_CTRL, 32'h241);
    pulse(2, 1'b1);
    wr(A_CTRL, 0); wr(A_CTRL, 32'h241);
    pulse(3, 1'b1);
    rd(A_CNT, rv); check("R11 phase cleared", rv, 0);
    pulse(1, 1'b1);
    rd(A_CNT, rv); check("R4 fourth tick advances", rv, 1);

    // R7 wait mode
    wr(A_CTRL, 0); wr(A_PRE, 0);
    waitMode = 1'b1;
    wr(A_CTRL, 32'h241);
    pulse(4, 1'b1);
    rd(A_CNT, rv); check("R7 frozen in wait", rv, 0);
    wr(A_CTRL, 32'h249);
    pulse(4, 1'b1);
    rd(A_CNT, rv); check("R7 counts with wait enable", rv, 4);
    waitMode = 1'b0;

    // R12 read-only counter and control readback
    wr(A_CNT, 32'h1234);
    rd(A_CNT, rv);  check("R12 counter write ignored", rv, 4);
    rd(A_CTRL, rv); check("R12 control readback", rv, 32'h249);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, rv); check("R12 control mask", rv, 32'h2C9);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule